// File: doc/BRIEF.md
# Serial Receiver with Break Hunting

This block is the receive half of a serial port that can also look for a break on a LIN bus. It takes the raw serial line, passes it through a two-stage synchronizer and looks at it only on a sample enable that runs at sixteen times the bit rate. Each frame has a start bit, eight data bits sent least significant bit first, and one stop bit.

A wait-for-break flag decides what happens to each frame. Software sets the flag with a one-cycle pulse.

- **Flag set:** the receiver drops ordinary frames without storing them and without raising errors. It waits instead for eleven low bit periods in a row. When it sees them it clears the flag. In any mode other than plain UART it also raises a break-success flag.
- **Flag clear:** the receiver acts as a plain UART. It checks the stop bit, detects overrun against a one-byte receive register, and pulses a status interrupt on any error. It pulses a completion strobe when it stores a byte.

Top module: `lnrx_top`

## Requirements
- R1: After reset, rx_data is 0x00 and every flag, strobe and status output is 0.
- R2: A start is accepted only when the line still reads low at the eighth sample tick after the first low tick. A low pulse that has gone high by then produces no frame, no flag and no strobe.
- R3: With the wait flag clear and the buffer empty, the eight data bits (the first one received is bit 0) are written to rx_data at the clock edge that samples the stop bit. At that same edge rx_full is set and rx_done pulses high for one cycle.
- R4: With the wait flag clear, a stop bit sampled low sets fe_flag and pulses err_irq at the stop-bit edge. If there is no overrun, the byte is still stored.
- R5: With the wait flag clear, a frame that completes while rx_full is 1 and rd_ack is 0 sets ove_flag and pulses err_irq. It leaves rx_data unchanged and gives no rx_done pulse.
- R6: While brk_wait is 1, completed frames change none of rx_data, rx_full, fe_flag and ove_flag, and they produce no rx_done or err_irq pulse.
- R7: While brk_wait is 1, a break (the start bit, all data bits, the stop bit and one further bit period all sampled low) clears brk_wait. In mode 00 (plain UART) brk_ok stays 0. The receiver then ignores the line until it has sampled it high, so the low tail of the break does not start a frame.
- R8: In any mode other than 00, a detected break sets brk_ok. A wait_set pulse clears brk_ok.
- R9: With brk_wait clear, a break is handled as a frame: data 0x00, a framing error and a stored byte. brk_wait stays 0.
- R10: An rd_ack pulse clears rx_full. An err_clr pulse clears fe_flag and ove_flag.
- R11: A wait_set pulse makes brk_wait 1 from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial input line, idle high |
| sample_en | input | 1 | Oversampling enable, 16 pulses per bit period |
| mode | input | 2 | Operation mode; 00 is plain UART |
| wait_set | input | 1 | Pulse that sets the wait-for-break flag |
| rd_ack | input | 1 | Pulse marking rx_data as read |
| err_clr | input | 1 | Pulse that clears the error flags |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive register holds an unread byte |
| rx_done | output | 1 | One-cycle pulse when a byte is stored |
| err_irq | output | 1 | One-cycle status interrupt on framing or overrun error |
| fe_flag | output | 1 | Framing error flag |
| ove_flag | output | 1 | Overrun error flag |
| brk_wait | output | 1 | Wait-for-break flag |
| brk_ok | output | 1 | Break received successfully |

## Verification
The internal line signal trails the rxd pin by two clocks because of the synchronizer. Every result of a frame then appears one clock after the sample-enable cycle that samples the stop bit (for a break, the cycle that samples the bit after the stop bit); this covers rx_data, rx_done, err_irq and the flags. Control pulses take effect in the cycle after they are driven. The bench's reference model applies its own two-register delay to the line it drives, counts enable ticks from the first low tick, and updates its expected outputs at the same edge. Each output is compared at the falling edge of every cycle. On top of that, directed checks read literal values once the line has been idle for two bit periods after each frame.

// File: rtl/lnrx_pkg.sv
package lnrx_pkg;

    localparam int RX_DW    = 8;
    localparam int RX_OVS   = 16;
    localparam int RX_SYNC  = 2;
    localparam int RX_MODE_W = 2;
    localparam logic [RX_MODE_W-1:0] RX_MODE_PLAIN = 2'b00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_BRK,
        ST_HIGH
    } rx_state_t;

    typedef struct packed {
        logic             stop_pt;
        logic             stop_hi;
        logic             brk;
        logic [RX_DW-1:0] data;
    } rx_evt_t;

    function automatic logic mode_is_plain(input logic [RX_MODE_W-1:0] m);
        return m == RX_MODE_PLAIN;
    endfunction

endpackage

// File: rtl/lnrx_sync.sv
module lnrx_sync #(
    parameter int STAGES = lnrx_pkg::RX_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= 1'b1;
                end else if (g == 0) begin
                    chain[g] <= d;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lnrx_frame.sv
module lnrx_frame
    import lnrx_pkg::*;
#(
    parameter int OVS = RX_OVS
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    lin,
    input  logic    wait_i,
    output rx_evt_t evt
);
    localparam int PH_W = $clog2(OVS);
    localparam int BI_W = $clog2(RX_DW + 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS/2 - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
    localparam logic [BI_W-1:0] BI_STOP = BI_W'(RX_DW);

    rx_state_t        st_q, st_d;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic [BI_W-1:0]  bi_q, bi_d;
    logic [RX_DW-1:0] sh_q, sh_d;
    logic             allz_q, allz_d;

    always_comb begin
        st_d   = st_q;
        ph_d   = ph_q;
        bi_d   = bi_q;
        sh_d   = sh_q;
        allz_d = allz_q;
        evt    = '0;
        evt.data = sh_q;
        if (tick) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (!lin) begin
                        st_d = ST_START;
                        ph_d = '0;
                    end
                end
                ST_START: begin
                    if (ph_q == PH_MID) begin
                        if (lin) begin
                            st_d = ST_IDLE;
                        end else begin
                            st_d   = ST_DATA;
                            ph_d   = '0;
                            bi_d   = '0;
                            allz_d = 1'b1;
                        end
                    end else begin
                        ph_d = ph_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (ph_q == PH_LAST) begin
                        ph_d = '0;
                        if (bi_q != BI_STOP) begin
                            sh_d   = {lin, sh_q[RX_DW-1:1]};
                            allz_d = allz_q & ~lin;
                            bi_d   = bi_q + 1'b1;
                        end else begin
                            evt.stop_pt = 1'b1;
                            evt.stop_hi = lin;
                            if (wait_i && allz_q && !lin) begin
                                st_d = ST_BRK;
                            end else if (lin) begin
                                st_d = ST_IDLE;
                            end else begin
                                st_d = ST_HIGH;
                            end
                        end
                    end else begin
                        ph_d = ph_q + 1'b1;
                    end
                end
                ST_BRK: begin
                    if (ph_q == PH_LAST) begin
                        if (!lin) begin
                            evt.brk = 1'b1;
                            st_d    = ST_HIGH;
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end else begin
                        ph_d = ph_q + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (lin) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ph_q   <= '0;
            bi_q   <= '0;
            sh_q   <= '0;
            allz_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ph_q   <= ph_d;
            bi_q   <= bi_d;
            sh_q   <= sh_d;
            allz_q <= allz_d;
        end
    end
endmodule

// File: rtl/lnrx_status.sv
module lnrx_status
    import lnrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  rx_evt_t              evt,
    input  logic [RX_MODE_W-1:0] mode,
    input  logic                 wait_set,
    input  logic                 rd_ack,
    input  logic                 err_clr,
    output logic [RX_DW-1:0]     rx_data,
    output logic                 rx_full,
    output logic                 rx_done,
    output logic                 err_irq,
    output logic                 fe_flag,
    output logic                 ove_flag,
    output logic                 brk_wait,
    output logic                 brk_ok
);
    logic take, ovr, frm, store;

    always_comb begin
        take  = evt.stop_pt && !brk_wait;
        ovr   = take && rx_full && !rd_ack;
        frm   = take && !evt.stop_hi;
        store = take && !ovr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_full  <= 1'b0;
            rx_done  <= 1'b0;
            err_irq  <= 1'b0;
            fe_flag  <= 1'b0;
            ove_flag <= 1'b0;
            brk_wait <= 1'b0;
            brk_ok   <= 1'b0;
        end else begin
            rx_done <= store;
            err_irq <= frm | ovr;
            if (store) rx_data <= evt.data;

            if (store)       rx_full <= 1'b1;
            else if (rd_ack) rx_full <= 1'b0;

            if (frm)          fe_flag <= 1'b1;
            else if (err_clr) fe_flag <= 1'b0;

            if (ovr)          ove_flag <= 1'b1;
            else if (err_clr) ove_flag <= 1'b0;

            if (wait_set)     brk_wait <= 1'b1;
            else if (evt.brk) brk_wait <= 1'b0;

            if (evt.brk && !mode_is_plain(mode)) brk_ok <= 1'b1;
            else if (wait_set)                   brk_ok <= 1'b0;
        end
    end
endmodule

// File: rtl/lnrx_top.sv
module lnrx_top
    import lnrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd,
    input  logic                 sample_en,
    input  logic [RX_MODE_W-1:0] mode,
    input  logic                 wait_set,
    input  logic                 rd_ack,
    input  logic                 err_clr,
    output logic [RX_DW-1:0]     rx_data,
    output logic                 rx_full,
    output logic                 rx_done,
    output logic                 err_irq,
    output logic                 fe_flag,
    output logic                 ove_flag,
    output logic                 brk_wait,
    output logic                 brk_ok
);
    logic    lin;
    rx_evt_t evt;

    lnrx_sync #(.STAGES(RX_SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (lin)
    );

    lnrx_frame #(.OVS(RX_OVS)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick   (sample_en),
        .lin    (lin),
        .wait_i (brk_wait),
        .evt    (evt)
    );

    lnrx_status u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .mode     (mode),
        .wait_set (wait_set),
        .rd_ack   (rd_ack),
        .err_clr  (err_clr),
        .rx_data  (rx_data),
        .rx_full  (rx_full),
        .rx_done  (rx_done),
        .err_irq  (err_irq),
        .fe_flag  (fe_flag),
        .ove_flag (ove_flag),
        .brk_wait (brk_wait),
        .brk_ok   (brk_ok)
    );
endmodule

// File: rtl/lnrx_chk.sv
module lnrx_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       rx_done,
    input logic       err_irq,
    input logic       fe_flag,
    input logic       ove_flag,
    input logic       brk_wait,
    input logic       brk_ok
);
    AST_DONE_FULL: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> rx_full);                                    // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);                                   // R3
    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> (fe_flag || ove_flag));                      // R4
    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (rst)
        $rose(ove_flag) |-> $stable(rx_data));                   // R5
    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        brk_wait |=> (!rx_done && !err_irq));                    // R6
    AST_PLAIN_NO_OK: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_ok) |-> ($past(mode) != 2'b00));               // R7
endmodule

bind lnrx_top lnrx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .rx_done  (rx_done),
    .err_irq  (err_irq),
    .fe_flag  (fe_flag),
    .ove_flag (ove_flag),
    .brk_wait (brk_wait),
    .brk_ok   (brk_ok)
);

// File: tb/lnrx_top_test.sv
`timescale 1ns/1ps
module lnrx_top_test;
    localparam int SE_DIV = 3;
    localparam int BITCLK = 16 * SE_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       sample_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       wait_set = 1'b0;
    logic       rd_ack = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_done, err_irq, fe_flag, ove_flag, brk_wait, brk_ok;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    bit cmp_on = 1'b0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    lnrx_top uut (
        .clk(clk), .rst(rst), .rxd(rxd), .sample_en(sample_en), .mode(mode),
        .wait_set(wait_set), .rd_ack(rd_ack), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .rx_done(rx_done), .err_irq(err_irq),
        .fe_flag(fe_flag), .ove_flag(ove_flag), .brk_wait(brk_wait), .brk_ok(brk_ok)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit       m_s1 = 1'b1, m_s2 = 1'b1;
    int       mst = 0, mt = 0, kk;
    bit [7:0] mb;
    bit       mallz;
    bit [7:0] e_data;
    bit       e_full, e_done, e_irq, e_fe, e_ove, e_wait, e_ok;

    always @(posedge clk) begin
        bit lv, sp, shv, bk, tk, ov, fr, sv;
        lv = m_s2; m_s2 = m_s1; m_s1 = rxd;
        if (rst) begin
            m_s1 = 1'b1; m_s2 = 1'b1; mst = 0; mt = 0;
            e_data = 8'h00; e_full = 0; e_done = 0; e_irq = 0;
            e_fe = 0; e_ove = 0; e_wait = 0; e_ok = 0;
        end else begin
            sp = 0; shv = 0; bk = 0;
            if (sample_en) begin
                if (mst == 0) begin
                    if (!lv) begin mst = 1; mt = 0; end
                end else if (mst == 1) begin
                    mt++;
                    if (mt == 8) begin
                        if (lv) mst = 0; else mallz = 1;
                    end else if (mt > 8 && (mt - 8) % 16 == 0) begin
                        kk = (mt - 8) / 16;
                        if (kk <= 8) begin
                            mb[kk-1] = lv;
                            if (lv) mallz = 0;
                        end else if (kk == 9) begin
                            sp = 1; shv = lv;
                            if (lv) mallz = 0;
                            if (!(e_wait && mallz)) mst = lv ? 0 : 2;
                        end else begin
                            if (!lv) begin bk = 1; mst = 2; end else mst = 0;
                        end
                    end
                end else begin
                    if (lv) mst = 0;
                end
            end
            tk = sp && !e_wait;
            ov = tk && e_full && !rd_ack;
            fr = tk && !shv;
            sv = tk && !ov;
            e_done = sv;
            e_irq = fr | ov;
            if (sv) e_data = mb;
            e_full = sv ? 1'b1 : (rd_ack ? 1'b0 : e_full);
            e_fe = fr ? 1'b1 : (err_clr ? 1'b0 : e_fe);
            e_ove = ov ? 1'b1 : (err_clr ? 1'b0 : e_ove);
            if (bk && mode != 2'b00) e_ok = 1'b1;
            else if (wait_set) e_ok = 1'b0;
            e_wait = wait_set ? 1'b1 : (bk ? 1'b0 : e_wait);
        end
    end

    always @(negedge clk) begin
        if (rx_done === 1'b1) done_cnt++;
        if (cmp_on && !ended) begin
            chk("R3 rx_data model", rx_data, e_data);
            chk("R10 rx_full model", rx_full, e_full);
            chk("R3 rx_done model", rx_done, e_done);
            chk("R4 err_irq model", err_irq, e_irq);
            chk("R4 fe_flag model", fe_flag, e_fe);
            chk("R5 ove_flag model", ove_flag, e_ove);
            chk("R11 brk_wait model", brk_wait, e_wait);
            chk("R8 brk_ok model", brk_ok, e_ok);
        end
    end

    initial begin
        int sc;
        sc = 0;
        forever begin
            @(negedge clk);
            sample_en = (sc == 0);
            sc = (sc + 1) % SE_DIV;
        end
    end

    task automatic put_bit(input bit v);
        rxd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send_frame(input bit [7:0] b, input bit stopv);
        put_bit(1'b0);
        for (int i = 0; i < 8; i++) put_bit(b[i]);
        put_bit(stopv);
        put_bit(1'b1);
        put_bit(1'b1);
    endtask

    task automatic send_break();
        for (int i = 0; i < 13; i++) put_bit(1'b0);
        put_bit(1'b1);
        put_bit(1'b1);
    endtask

    task automatic pulse(input int which);
        if (which == 0) wait_set = 1'b1;
        else if (which == 1) rd_ack = 1'b1;
        else err_clr = 1'b1;
        @(negedge clk);
        wait_set = 1'b0; rd_ack = 1'b0; err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int d0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_data", rx_data, 8'h00);
        chk("R1 flags", {rx_full, rx_done, err_irq, fe_flag, ove_flag, brk_wait, brk_ok}, 0);
        cmp_on = 1'b1;
        put_bit(1'b1);

        // R3 normal reception
        send_frame(8'hA5, 1'b1);
        chk("R3 data A5", rx_data, 8'hA5);
        chk("R3 full", rx_full, 1);
        chk("R3 done count", done_cnt, 1);
        chk("R4 no fe on good stop", fe_flag, 0);
        pulse(1);
        chk("R10 rd_ack clears full", rx_full, 0);

        // R4 framing error still stores
        send_frame(8'h3C, 1'b0);
        chk("R4 fe set", fe_flag, 1);
        chk("R4 data stored", rx_data, 8'h3C);
        pulse(2);
        chk("R10 err_clr clears fe", fe_flag, 0);

        // R5 overrun keeps old byte
        d0 = done_cnt;
        send_frame(8'h77, 1'b1);
        chk("R5 ove set", ove_flag, 1);
        chk("R5 old byte kept", rx_data, 8'h3C);
        chk("R5 no done", done_cnt, d0);
        pulse(1);
        pulse(2);
        chk("R10 err_clr clears ove", ove_flag, 0);

        // R2 glitch
        d0 = done_cnt;
        rxd = 1'b0;
        repeat (4 * SE_DIV) @(negedge clk);
        put_bit(1'b1);
        put_bit(1'b1);
        chk("R2 glitch no frame", done_cnt, d0);
        chk("R2 glitch no fe", fe_flag, 0);

        // R11 / R6 wait-for-break discards frames
        pulse(0);
        chk("R11 wait set", brk_wait, 1);
        send_frame(8'h5A, 1'b0);
        chk("R6 no fe", fe_flag, 0);
        chk("R6 data kept", rx_data, 8'h3C);
        chk("R6 full kept", rx_full, 0);
        chk("R6 no done", done_cnt, d0);

        // R7 break in plain mode
        send_break();
        chk("R7 wait cleared", brk_wait, 0);
        chk("R7 no brk_ok in plain", brk_ok, 0);
        chk("R7 tail ignored", done_cnt, d0);
        send_frame(8'h96, 1'b1);
        chk("R7 normal after break", rx_data, 8'h96);
        pulse(1);

        // R8 break in other mode
        mode = 2'b01;
        pulse(0);
        send_break();
        chk("R8 brk_ok set", brk_ok, 1);
        chk("R8 wait cleared", brk_wait, 0);
        pulse(0);
        chk("R8 brk_ok cleared", brk_ok, 0);
        chk("R11 wait set again", brk_wait, 1);
        send_break();
        chk("R8 second break", brk_ok, 1);
        mode = 2'b00;

        // R9 break with wait clear
        d0 = done_cnt;
        send_break();
        chk("R9 fe set", fe_flag, 1);
        chk("R9 data zero", rx_data, 8'h00);
        chk("R9 stored", done_cnt, d0 + 1);
        chk("R9 wait stays clear", brk_wait, 0);

        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule